// File: doc/BRIEF.md
# Bit-Serial SIMD Processing Array

This block is a rectangular grid of tiny processing elements (PEs) whose registers and datapath are all one bit wide. None of the PEs fetches or decodes anything. An external sequencer presents one control word per clock, and every PE obeys the same control word in the same cycle. The control word is made of an operation, an operand source, a source register index, a destination register index, a conditional flag and an immediate bit. Each PE holds `NREG` one-bit general registers, a carry flip-flop for bit-serial addition, and an activity mask. Conditional operations take effect only where the mask is set.

An operand can come from the PE's own register file, from the same-indexed register of the PE above, below, to the left or to the right, from the broadcast immediate, or from the PE's own mask. The sequencer sees the array through one OR-reduction tree. A select input chooses which state bit every PE offers to the tree. A per-PE enable vector chooses which PEs take part. With every PE enabled the tree output tells the sequencer whether any PE holds a one. With a single PE enabled, the output reads that PE's bit.

An if/else runs as four broadcasts: load the mask from the condition bit, issue the then-part with the conditional flag set, invert the mask, then issue the else-part with the flag set.

Top module: `simd_array`

## Requirements
- R1: After reset every general register and every carry flip-flop holds 0, and every mask holds 1.
- R2: Logic operations write the destination register `d` from its old value and the operand `x`: COPY (op 1) gives x, AND (op 2) gives d&x, OR (op 3) gives d|x, XOR (op 4) gives d^x, NOT (op 5) gives ~x.
- R3: ADD (op 6) writes d^x^c into the destination and writes the majority of d, x and c into the carry `c`. LDCARRY (op 9) writes the operand into the carry.
- R4: Source codes pick the operand: 0 selects the PE's own register at the source index, 5 the broadcast immediate, 6 the PE's own mask.
- R5: Source codes 1, 2, 3 and 4 read the source-indexed register of the PE one row up, one column right, one row down and one column left. Row 0 is the top row and column 0 is the left column; PE index is row*COLS+column.
- R6: A neighbour read that would leave the grid returns 0; there is no wraparound.
- R7: With the conditional flag at 1, a PE whose mask is 0 keeps its registers and carry unchanged under ops 1 to 6 and 9.
- R8: LDMASK (op 7) loads the mask from the operand and INVMASK (op 8) inverts it, in every PE, whatever the conditional flag and the current mask.
- R9: The tree output is the OR, over PEs whose enable bit is 1, of the selected state bit: register k for a select value k < NREG, the mask for NREG, and the carry for NREG+1. It responds in the same cycle.
- R10: With exactly one enable bit set, the tree output equals that PE's selected bit. With no enable bits set, it is 0.
- R11: Op 0 and the unused codes 10 to 15 change no state.
- R12: A broadcast operation takes effect at the next rising clock edge. Before that edge the tree still shows the old state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 4 | Broadcast operation code |
| src_i | input | 3 | Operand source code |
| src_reg_i | input | RSEL_W | Register index read as operand, locally or from a neighbour |
| dst_reg_i | input | RSEL_W | Register index written |
| cond_i | input | 1 | 1 = operation is gated by each PE's mask |
| imm_i | input | 1 | Broadcast immediate bit |
| tree_sel_i | input | TSEL_W | State bit offered to the OR tree |
| pe_en_i | input | ROWS*COLS | Per-PE enable into the OR tree |
| any_o | output | 1 | OR-tree result |

## Verification
All state changes appear one rising edge after the control word is presented. The tree output is combinational, so it is due within the same cycle as a change of select or enable. The bench drives each control word on a falling edge. Before the next rising edge it samples the tree once to confirm the old state still shows. After the edge it sets the operation back to 0 and reads every state bit of every PE one at a time through single-PE enables, and it also reads the all-enabled OR and the all-disabled output. All of these are compared with a behavioural model that is updated at that same edge.

// File: rtl/simd_pkg.sv
// Package: shared encodings for the bit-serial SIMD array.
// Assumes: op and source codes are fixed by the broadcast control format.
package simd_pkg;

    typedef enum logic [3:0] {
        OP_NOP     = 4'd0,
        OP_COPY    = 4'd1,
        OP_AND     = 4'd2,
        OP_OR      = 4'd3,
        OP_XOR     = 4'd4,
        OP_NOT     = 4'd5,
        OP_ADD     = 4'd6,
        OP_LDMASK  = 4'd7,
        OP_INVMASK = 4'd8,
        OP_LDCARRY = 4'd9
    } op_e;

    typedef enum logic [2:0] {
        SRC_REG  = 3'd0,
        SRC_N    = 3'd1,
        SRC_E    = 3'd2,
        SRC_S    = 3'd3,
        SRC_W    = 3'd4,
        SRC_IMM  = 3'd5,
        SRC_MASK = 3'd6
    } src_e;

    // Bits arriving from the four mesh neighbours
    typedef struct packed {
        logic n;
        logic e;
        logic s;
        logic w;
    } nbr_t;

endpackage

// File: rtl/simd_pe.sv
// Module: one bit-serial processing element.
// Holds NREG one-bit registers, a carry and a mask; executes the broadcast
// control word each cycle. Assumes NREG is a power of two so every register
// index is in range. Mask operations ignore the conditional flag.
module simd_pe
    import simd_pkg::*;
#(
    parameter int NREG   = 4,
    parameter int RSEL_W = 2,
    parameter int TSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [2:0]        src_i,
    input  logic [RSEL_W-1:0] src_reg_i,
    input  logic [RSEL_W-1:0] dst_reg_i,
    input  logic              cond_i,
    input  logic              imm_i,
    input  nbr_t              nbr_i,
    input  logic [TSEL_W-1:0] tree_sel_i,
    input  logic              tree_en_i,
    output logic [NREG-1:0]   regs_o,
    output logic              mask_o,
    output logic              carry_o,
    output logic              tree_bit_o
);

    logic [NREG-1:0] regs_q;
    logic            mask_q;
    logic            carry_q;
    logic            opd;
    logic            acc;
    logic            res;
    logic            carry_nx;
    logic            reg_we;
    logic            carry_we;
    logic            allow_w;

    // Purpose: select the operand bit from the broadcast source code
    always_comb begin
        unique case (src_i)
            SRC_REG:  opd = regs_q[src_reg_i];
            SRC_N:    opd = nbr_i.n;
            SRC_E:    opd = nbr_i.e;
            SRC_S:    opd = nbr_i.s;
            SRC_W:    opd = nbr_i.w;
            SRC_IMM:  opd = imm_i;
            SRC_MASK: opd = mask_q;
            default:  opd = 1'b0;
        endcase
    end

    assign acc     = regs_q[dst_reg_i];
    assign allow_w = !cond_i || mask_q;

    // Purpose: compute the result bit, next carry and write enables
    always_comb begin
        res      = 1'b0;
        carry_nx = carry_q;
        reg_we   = 1'b0;
        carry_we = 1'b0;
        unique case (op_i)
            OP_COPY: begin res = opd;        reg_we = 1'b1; end
            OP_AND:  begin res = acc & opd;  reg_we = 1'b1; end
            OP_OR:   begin res = acc | opd;  reg_we = 1'b1; end
            OP_XOR:  begin res = acc ^ opd;  reg_we = 1'b1; end
            OP_NOT:  begin res = ~opd;       reg_we = 1'b1; end
            OP_ADD: begin
                res      = acc ^ opd ^ carry_q;
                carry_nx = (acc & opd) | (acc & carry_q) | (opd & carry_q);
                reg_we   = 1'b1;
                carry_we = 1'b1;
            end
            OP_LDCARRY: begin carry_nx = opd; carry_we = 1'b1; end
            default: ;
        endcase
    end

    // Purpose: update the general registers under the mask condition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (reg_we && allow_w) begin
            for (int k = 0; k < NREG; k++) begin
                if (k == int'(dst_reg_i)) regs_q[k] <= res;
            end
        end
    end

    // Purpose: update the carry flip-flop under the mask condition
    always_ff @(posedge clk) begin
        if (!rst_n)                     carry_q <= 1'b0;
        else if (carry_we && allow_w)   carry_q <= carry_nx;
    end

    // Purpose: load or invert the mask, never gated by the mask itself
    always_ff @(posedge clk) begin
        if (!rst_n)                    mask_q <= 1'b1;
        else if (op_i == OP_LDMASK)    mask_q <= opd;
        else if (op_i == OP_INVMASK)   mask_q <= ~mask_q;
    end

    // Purpose: offer the selected state bit to the OR tree when enabled
    always_comb begin
        logic st;
        if (int'(tree_sel_i) < NREG)       st = regs_q[tree_sel_i[RSEL_W-1:0]];
        else if (int'(tree_sel_i) == NREG) st = mask_q;
        else if (int'(tree_sel_i) == NREG + 1) st = carry_q;
        else                                st = 1'b0;
        tree_bit_o = st & tree_en_i;
    end

    assign regs_o  = regs_q;
    assign mask_o  = mask_q;
    assign carry_o = carry_q;

endmodule

// File: rtl/simd_or_tree.sv
// Module: balanced binary OR-reduction tree.
// Pads the leaf count to a power of two with zeros; purely combinational.
module simd_or_tree #(
    parameter int N = 16
) (
    input  logic [N-1:0] leaves_i,
    output logic         any_o
);

    localparam int P = (N < 2) ? 1 : (1 << $clog2(N));

    logic [2*P-1:1] node;

    // Purpose: place leaves (and zero padding) at the bottom level
    for (genvar j = 0; j < P; j++) begin : g_leaf
        if (j < N) begin : g_real
            assign node[P+j] = leaves_i[j];
        end else begin : g_pad
            assign node[P+j] = 1'b0;
        end
    end

    // Purpose: combine pairs of children into each inner node
    for (genvar i = 1; i < P; i++) begin : g_node
        assign node[i] = node[2*i] | node[2*i+1];
    end

    assign any_o = node[1];

endmodule

// File: rtl/simd_array.sv
// Module: ROWS x COLS grid of bit-serial PEs sharing one broadcast control
// word, with mesh neighbour wiring (zero at the edges) and an OR tree for
// global status and single-PE readout. Assumes NREG is a power of two >= 2.
module simd_array
    import simd_pkg::*;
#(
    parameter int  ROWS   = 4,
    parameter int  COLS   = 4,
    parameter int  NREG   = 4,
    localparam int NPE    = ROWS * COLS,
    localparam int RSEL_W = $clog2(NREG),
    localparam int TSEL_W = $clog2(NREG + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [2:0]        src_i,
    input  logic [RSEL_W-1:0] src_reg_i,
    input  logic [RSEL_W-1:0] dst_reg_i,
    input  logic              cond_i,
    input  logic              imm_i,
    input  logic [TSEL_W-1:0] tree_sel_i,
    input  logic [NPE-1:0]    pe_en_i,
    output logic              any_o
);

    logic [NPE*NREG-1:0] reg_flat;
    logic [NPE-1:0]      mask_all;
    logic [NPE-1:0]      carry_all;
    logic [NPE-1:0]      share_bit;
    logic [NPE-1:0]      tree_bits;

    // Purpose: each PE exposes its source-indexed register to its neighbours
    for (genvar p = 0; p < NPE; p++) begin : g_share
        assign share_bit[p] = reg_flat[p*NREG + int'(src_reg_i)];
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int IDX = r * COLS + c;
            nbr_t nbr;

            // Purpose: wire mesh neighbours, tying off edges to zero
            if (r > 0) begin : g_n
                assign nbr.n = share_bit[IDX - COLS];
            end else begin : g_n0
                assign nbr.n = 1'b0;
            end
            if (r < ROWS - 1) begin : g_s
                assign nbr.s = share_bit[IDX + COLS];
            end else begin : g_s0
                assign nbr.s = 1'b0;
            end
            if (c > 0) begin : g_w
                assign nbr.w = share_bit[IDX - 1];
            end else begin : g_w0
                assign nbr.w = 1'b0;
            end
            if (c < COLS - 1) begin : g_e
                assign nbr.e = share_bit[IDX + 1];
            end else begin : g_e0
                assign nbr.e = 1'b0;
            end

            simd_pe #(
                .NREG   (NREG),
                .RSEL_W (RSEL_W),
                .TSEL_W (TSEL_W)
            ) u_pe (
                .clk        (clk),
                .rst_n      (rst_n),
                .op_i       (op_i),
                .src_i      (src_i),
                .src_reg_i  (src_reg_i),
                .dst_reg_i  (dst_reg_i),
                .cond_i     (cond_i),
                .imm_i      (imm_i),
                .nbr_i      (nbr),
                .tree_sel_i (tree_sel_i),
                .tree_en_i  (pe_en_i[IDX]),
                .regs_o     (reg_flat[IDX*NREG +: NREG]),
                .mask_o     (mask_all[IDX]),
                .carry_o    (carry_all[IDX]),
                .tree_bit_o (tree_bits[IDX])
            );
        end
    end

    simd_or_tree #(
        .N (NPE)
    ) u_tree (
        .leaves_i (tree_bits),
        .any_o    (any_o)
    );

endmodule

// File: rtl/simd_array_chk.sv
// Module: property checker for simd_array, attached with bind.
// Observes ports plus the per-PE state vectors gathered in the top.
module simd_array_chk
    import simd_pkg::*;
#(
    parameter int NPE    = 16,
    parameter int NREG   = 4,
    parameter int TSEL_W = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [3:0]          op_i,
    input logic [2:0]          src_i,
    input logic                cond_i,
    input logic                imm_i,
    input logic [TSEL_W-1:0]   tree_sel_i,
    input logic [NPE-1:0]      pe_en_i,
    input logic                any_o,
    input logic [NPE-1:0]      mask_all,
    input logic [NPE-1:0]      carry_all,
    input logic [NPE*NREG-1:0] reg_flat
);

    assert_mask_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_LDMASK && src_i == SRC_IMM) |=> (mask_all == {NPE{$past(imm_i)}}));

    assert_mask_invert_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_INVMASK) |=> (mask_all == ~$past(mask_all)));

    assert_masked_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i && mask_all == '0 && op_i != OP_LDMASK && op_i != OP_INVMASK)
        |=> ($stable(reg_flat) && $stable(carry_all)));

    assert_nop_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_NOP || op_i > 4'd9)
        |=> ($stable(reg_flat) && $stable(mask_all) && $stable(carry_all)));

    assert_tree_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_en_i == '0) |-> !any_o);

    assert_tree_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> (pe_en_i != '0 && int'(tree_sel_i) < NREG + 2));

endmodule

bind simd_array simd_array_chk #(
    .NPE    (NPE),
    .NREG   (NREG),
    .TSEL_W (TSEL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_i       (op_i),
    .src_i      (src_i),
    .cond_i     (cond_i),
    .imm_i      (imm_i),
    .tree_sel_i (tree_sel_i),
    .pe_en_i    (pe_en_i),
    .any_o      (any_o),
    .mask_all   (mask_all),
    .carry_all  (carry_all),
    .reg_flat   (reg_flat)
);

// File: tb/test_simd_array.sv
// Bench: behavioural model of every PE's state, updated per broadcast and
// compared through the OR tree after each clock edge.
module test_simd_array;
    import simd_pkg::*;

    localparam int ROWS = 4;
    localparam int COLS = 4;
    localparam int NREG = 4;
    localparam int NPE  = ROWS * COLS;
    localparam int RW   = $clog2(NREG);
    localparam int TW   = $clog2(NREG + 2);

    logic          clk = 1'b0;
    logic          rst_n;
    logic [3:0]    op_i;
    logic [2:0]    src_i;
    logic [RW-1:0] src_reg_i;
    logic [RW-1:0] dst_reg_i;
    logic          cond_i;
    logic          imm_i;
    logic [TW-1:0] tree_sel_i;
    logic [NPE-1:0] pe_en_i;
    logic          any_o;

    int checks = 0;
    int fails  = 0;

    bit reg_m   [NPE][NREG];
    bit mask_m  [NPE];
    bit carry_m [NPE];

    always #5 clk = ~clk;

    simd_array #(.ROWS(ROWS), .COLS(COLS), .NREG(NREG)) i_simd_array (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .src_i(src_i),
        .src_reg_i(src_reg_i), .dst_reg_i(dst_reg_i), .cond_i(cond_i),
        .imm_i(imm_i), .tree_sel_i(tree_sel_i), .pe_en_i(pe_en_i), .any_o(any_o)
    );

    task automatic check(input logic act, input bit exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    function automatic bit model_bit(int p, int s);
        if (s < NREG)  return reg_m[p][s];
        if (s == NREG) return mask_m[p];
        return carry_m[p];
    endfunction

    // Read every state bit of every PE, then the global OR, then no-enable
    task automatic sweep(input string req);
        for (int p = 0; p < NPE; p++) begin
            for (int s = 0; s < NREG + 2; s++) begin
                pe_en_i    = NPE'(1) << p;
                tree_sel_i = TW'(s);
                #1;
                check(any_o, model_bit(p, s), req, $sformatf("pe %0d sel %0d", p, s));
            end
        end
        for (int s = 0; s < NREG + 2; s++) begin
            bit ex = 0;
            for (int p = 0; p < NPE; p++) ex |= model_bit(p, s);
            pe_en_i    = '1;
            tree_sel_i = TW'(s);
            #1;
            check(any_o, ex, "R9", $sformatf("global any sel %0d", s));
        end
        pe_en_i = '0;
        #1;
        check(any_o, 1'b0, "R10", "no enables");
    endtask

    task automatic exec(input logic [3:0] op, input logic [2:0] src, input int sreg,
                        input int dreg, input bit cnd, input bit imm, input string req);
        bit nreg [NPE][NREG];
        bit nmask [NPE];
        bit ncar [NPE];
        bit old_any;
        @(negedge clk);
        op_i = op; src_i = src; src_reg_i = RW'(sreg); dst_reg_i = RW'(dreg);
        cond_i = cnd; imm_i = imm;
        old_any = 0;
        for (int p = 0; p < NPE; p++) old_any |= reg_m[p][dreg];
        tree_sel_i = TW'(dreg); pe_en_i = '1;
        #1;
        check(any_o, old_any, "R12", "before edge");
        for (int p = 0; p < NPE; p++) begin
            int r = p / COLS;
            int c = p % COLS;
            bit x, d, ok;
            case (src)
                3'd0: x = reg_m[p][sreg];
                3'd1: x = (r > 0)        ? reg_m[p-COLS][sreg] : 1'b0;
                3'd2: x = (c < COLS - 1) ? reg_m[p+1][sreg]    : 1'b0;
                3'd3: x = (r < ROWS - 1) ? reg_m[p+COLS][sreg] : 1'b0;
                3'd4: x = (c > 0)        ? reg_m[p-1][sreg]    : 1'b0;
                3'd5: x = imm;
                3'd6: x = mask_m[p];
                default: x = 1'b0;
            endcase
            nreg[p] = reg_m[p]; nmask[p] = mask_m[p]; ncar[p] = carry_m[p];
            d  = reg_m[p][dreg];
            ok = !cnd || mask_m[p];
            case (op)
                4'd1: if (ok) nreg[p][dreg] = x;
                4'd2: if (ok) nreg[p][dreg] = d & x;
                4'd3: if (ok) nreg[p][dreg] = d | x;
                4'd4: if (ok) nreg[p][dreg] = d ^ x;
                4'd5: if (ok) nreg[p][dreg] = !x;
                4'd6: if (ok) begin
                    nreg[p][dreg] = d ^ x ^ carry_m[p];
                    ncar[p] = (d && x) || (d && carry_m[p]) || (x && carry_m[p]);
                end
                4'd7: nmask[p] = x;
                4'd8: nmask[p] = !mask_m[p];
                4'd9: if (ok) ncar[p] = x;
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        reg_m = nreg; mask_m = nmask; carry_m = ncar;
        op_i = 4'd0; cond_i = 1'b0;
        sweep(req);
    endtask

    initial begin
        #(10 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; op_i = 4'd0; src_i = 3'd0; src_reg_i = '0; dst_reg_i = '0;
        cond_i = 1'b0; imm_i = 1'b0; tree_sel_i = '0; pe_en_i = '0;
        for (int p = 0; p < NPE; p++) begin
            mask_m[p] = 1'b1; carry_m[p] = 1'b0;
            for (int k = 0; k < NREG; k++) reg_m[p][k] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        sweep("R1");

        exec(OP_COPY,   SRC_IMM,  0, 0, 0, 1, "R2");   // r0 all ones
        exec(OP_COPY,   SRC_N,    0, 1, 0, 0, "R6");   // top row reads zero
        exec(OP_COPY,   SRC_W,    1, 2, 0, 0, "R6");   // left column reads zero
        exec(OP_COPY,   SRC_E,    2, 3, 0, 0, "R5");
        exec(OP_XOR,    SRC_S,    1, 3, 0, 0, "R5");
        exec(OP_AND,    SRC_REG,  2, 0, 0, 0, "R2");
        exec(OP_OR,     SRC_REG,  3, 1, 0, 0, "R2");
        exec(OP_NOT,    SRC_REG,  1, 3, 0, 0, "R2");
        exec(OP_LDMASK, SRC_REG,  2, 0, 0, 0, "R8");   // if: mask from condition
        exec(OP_COPY,   SRC_IMM,  0, 3, 1, 1, "R7");   // then-part
        exec(OP_INVMASK, SRC_REG, 0, 0, 1, 0, "R8");   // invert, flag ignored
        exec(OP_COPY,   SRC_IMM,  0, 3, 1, 0, "R7");   // else-part
        exec(OP_LDCARRY, SRC_IMM, 0, 0, 0, 1, "R3");
        exec(OP_ADD,    SRC_REG,  1, 0, 0, 0, "R3");
        exec(OP_ADD,    SRC_W,    0, 2, 0, 0, "R3");
        exec(OP_ADD,    SRC_IMM,  0, 1, 1, 1, "R7");   // masked add
        exec(OP_LDMASK, SRC_IMM,  0, 0, 0, 0, "R8");   // all masks off
        exec(OP_COPY,   SRC_IMM,  0, 0, 1, 1, "R7");   // nobody writes
        exec(OP_LDCARRY, SRC_IMM, 0, 0, 1, 0, "R7");   // carry held
        exec(OP_LDMASK, SRC_IMM,  0, 0, 1, 1, "R8");   // flag set, still loads
        exec(OP_COPY,   SRC_MASK, 0, 1, 0, 0, "R4");
        exec(4'd13,     SRC_IMM,  0, 0, 0, 1, "R11");
        exec(OP_NOP,    SRC_IMM,  0, 2, 0, 1, "R11");
        exec(OP_COPY,   SRC_REG,  3, 0, 0, 0, "R4");
        exec(OP_LDCARRY, SRC_N,   2, 0, 0, 0, "R3");
        exec(OP_XOR,    SRC_IMM,  0, 2, 0, 1, "R2");
        exec(OP_ADD,    SRC_E,    2, 3, 0, 0, "R5");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule